// File: doc/BRIEF.md
# Seconds Counter with One-Shot Alarm

This block keeps a free-running 32-bit count of seconds and compares it against a programmable alarm. It is for an always-on part of a chip. A prescaler divides the reference clock into one-second steps. Software reaches two 32-bit registers over a minimal write/read bus: the time register and the alarm control register.

Writes to the time register are guarded, so a single stray store cannot change the count. A new value is taken only when the same word is written twice, and the second write must come at least a set number of reference cycles after the first. The alarm is 25 bits wide and has an enable flag and a sticky pending flag. When the count reaches the alarm value with the alarm enabled, the pending flag sets and the alarm value goes back to all ones. The wake output then rises, and a downstream wake-up controller can treat that rise as an edge event.

Top module: `secalm_top`

## Requirements
- R1: After reset the time register reads 0, the alarm register reads 0x01FFFFFF (value field all ones, enable and pending clear), and wake is low.
- R2: The time count increases by exactly one every TICK_DIV clock cycles and wraps from 0xFFFFFFFF to 0. After an accepted load, the next increment comes TICK_DIV cycles after the load cycle.
- R3: A write to address 0 (time) loads the count only when it carries the same data as the previous time write and comes at least LOAD_GAP cycles after it. The loaded value reads back on the next cycle.
- R4: A lone time write, or a second write whose data differs from the first, leaves the count running unchanged. A rejected write becomes the new first write.
- R5: A matching second time write that arrives fewer than LOAD_GAP cycles after the first is rejected and becomes the new first write.
- R6: The alarm register is at address 1. Bits 24:0 hold the alarm value, bit 25 the enable and bit 26 the pending flag. Bits 31:27 read as zero, and writes to them are ignored.
- R7: When the count steps to a value whose low 25 bits equal the alarm value, with enable set and pending clear, pending sets and the alarm value returns to all ones on the same edge. Count bits above 24 take no part in the compare.
- R8: With enable clear, a matching count step does not set pending or raise wake.
- R9: Wake is high exactly while pending and enable are both set. Clearing enable drops wake and leaves pending set.
- R10: Writing 1 to bit 26 of the alarm register clears pending. Writing 0 to bit 26 leaves pending unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | Register select: 0 time, 1 alarm control |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register (combinational) |
| wake | output | 1 | Level wake request, rises when the alarm fires |

## Verification
The bench builds the block with TICK_DIV = 8 and LOAD_GAP = 5. With these values a second passes in a few cycles, so the bench can sample the count at an exact cycle offset from a load. It can also hit the load guard at both edges of its window: four cycles after the first write, where the second write is rejected, and five cycles, where it is accepted. The short second also lets the bench run a 32-bit rollover and a full alarm countdown within a few dozen cycles of a chosen load.

// File: rtl/secalm_pkg.sv
// Package: shared widths, register addresses and field layout for the
// seconds counter with alarm. Assumes a 32-bit data bus.
package secalm_pkg;
    localparam int TIME_W   = 32;
    localparam int ALARM_W  = 25;
    localparam int EN_BIT   = 25;
    localparam int PEND_BIT = 26;

    localparam logic ADDR_TIME  = 1'b0;
    localparam logic ADDR_ALARM = 1'b1;

    // Alarm control state as held in flops.
    typedef struct packed {
        logic               pend;
        logic               en;
        logic [ALARM_W-1:0] value;
    } alarm_state_t;

    localparam logic [ALARM_W-1:0] ALARM_IDLE = '1;
endpackage

// File: rtl/secalm_prescaler.sv
// Prescaler: divides the reference clock into a one-cycle seconds tick.
// Assumes TICK_DIV >= 1. A restart pulse zeroes the phase, so the next
// tick follows TICK_DIV cycles after the restart edge.
module secalm_prescaler #(
    parameter int TICK_DIV = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] phase_q;

    assign tick = (phase_q == LAST);

    // Phase counter: wraps on the tick, zeroed by reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CW'(1);
        end
    end

    generate
        if (TICK_DIV > 1) begin : g_spacing
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);  // R2
        end
    endgenerate
endmodule

// File: rtl/secalm_load_guard.sv
// Load guard: accepts a time write only when it repeats the previous
// time write's data at least LOAD_GAP cycles later. Any write that is
// not accepted becomes the new first write. Assumes LOAD_GAP >= 1.
module secalm_load_guard #(
    parameter int LOAD_GAP = 8,
    parameter int DW       = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_time,
    input  logic [DW-1:0] wdata,
    output logic          load,
    output logic [DW-1:0] load_val
);
    localparam int GW = $clog2(LOAD_GAP + 1);
    localparam logic [GW-1:0] GAP_MAX = GW'(LOAD_GAP);

    logic          armed_q;
    logic [DW-1:0] held_q;
    logic [GW-1:0] gap_q;
    logic          gap_done;

    assign gap_done = (gap_q >= GAP_MAX);
    assign load     = wr_time && armed_q && gap_done && (wdata == held_q);
    assign load_val = held_q;

    // Arm state: first write arms, accepted second write disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (wr_time) begin
            armed_q <= !load;
        end
    end

    // Held word: captured from every write that is not accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (wr_time && !load) begin
            held_q <= wdata;
        end
    end

    // Gap timer: starts at one on a first write, saturates at LOAD_GAP.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (wr_time && !load) begin
            gap_q <= GW'(1);
        end else if (armed_q && !gap_done) begin
            gap_q <= gap_q + GW'(1);
        end
    end

    AST_LOAD_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(wr_time) || armed_q);  // R4
    AST_LOAD_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !armed_q);  // R5
endmodule

// File: rtl/secalm_time_cnt.sv
// Time counter: 32-bit seconds count, advanced by the tick and
// overwritten by an accepted load (a load wins over a tick).
module secalm_time_cnt #(
    parameter int TW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] count,
    output logic          advance,
    output logic [TW-1:0] count_next
);
    logic [TW-1:0] count_q;

    assign count      = count_q;
    assign advance    = tick && !load;
    assign count_next = count_q + TW'(1);

    // Count register: load, else step on tick, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (tick) begin
            count_q <= count_next;
        end
    end

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count_q == $past(load_val));  // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(count_q));  // R2
endmodule

// File: rtl/secalm_alarm.sv
// Alarm: holds the 25-bit alarm value with its enable and pending flags,
// fires one shot on a matching count step, and drives the wake level.
// A register write in the same cycle takes priority over firing, so a
// reprogramming sequence never fires off a half-written state.
module secalm_alarm
    import secalm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_alarm,
    input  logic [31:0]        wdata,
    input  logic               advance,
    input  logic [ALARM_W-1:0] next_low,
    output alarm_state_t       state,
    output logic               wake
);
    alarm_state_t st_q;
    logic         fire;

    assign fire  = advance && st_q.en && !st_q.pend && !wr_alarm
                   && (next_low == st_q.value);
    assign state = st_q;
    assign wake  = st_q.pend && st_q.en;

    // Control state: writes first, then firing, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.value <= ALARM_IDLE;
            st_q.en    <= 1'b0;
            st_q.pend  <= 1'b0;
        end else if (wr_alarm) begin
            st_q.value <= wdata[ALARM_W-1:0];
            st_q.en    <= wdata[EN_BIT];
            st_q.pend  <= st_q.pend && !wdata[PEND_BIT];
        end else if (fire) begin
            st_q.value <= ALARM_IDLE;
            st_q.pend  <= 1'b1;
        end
    end

    AST_FIRE_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_alarm) && $rose(st_q.pend)) |-> st_q.value == ALARM_IDLE);  // R7
    AST_NO_FIRE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en && !st_q.pend) |=> !st_q.pend);  // R8
    AST_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_alarm && wdata[PEND_BIT]) |=> !st_q.pend);  // R10
    AST_WAKE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_alarm && !wdata[EN_BIT]) |=> !wake);  // R9
endmodule

// File: rtl/secalm_top.sv
// Top: seconds counter with one-shot alarm behind a two-register bus.
// Address 0 is the guarded time register, address 1 the alarm control.
// Assumes bus_wr is a one-cycle strobe; reads are combinational.
module secalm_top
    import secalm_pkg::*;
#(
    parameter int TICK_DIV = 32768,
    parameter int LOAD_GAP = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wake
);
    logic              wr_time, wr_alarm;
    logic              tick, load, advance;
    logic [TIME_W-1:0] load_val, count, count_next;
    alarm_state_t      alarm_st;

    assign wr_time  = bus_wr && (bus_addr == ADDR_TIME);
    assign wr_alarm = bus_wr && (bus_addr == ADDR_ALARM);

    secalm_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk(clk), .rst_n(rst_n), .restart(load), .tick(tick)
    );

    secalm_load_guard #(.LOAD_GAP(LOAD_GAP), .DW(TIME_W)) u_guard (
        .clk(clk), .rst_n(rst_n), .wr_time(wr_time), .wdata(bus_wdata),
        .load(load), .load_val(load_val)
    );

    secalm_time_cnt #(.TW(TIME_W)) u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_val(load_val), .count(count), .advance(advance),
        .count_next(count_next)
    );

    secalm_alarm u_alarm (
        .clk(clk), .rst_n(rst_n), .wr_alarm(wr_alarm), .wdata(bus_wdata),
        .advance(advance), .next_low(count_next[ALARM_W-1:0]),
        .state(alarm_st), .wake(wake)
    );

    // Read mux: unused upper alarm bits read as zero.
    always_comb begin
        if (bus_addr == ADDR_TIME) begin
            bus_rdata = count;
        end else begin
            bus_rdata = {{(32 - ALARM_W - 2){1'b0}}, alarm_st};
        end
    end

    AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(bus_wdata));  // R3
endmodule

// File: tb/tb_secalm_top.sv
`timescale 1ns/1ps
module tb_secalm_top;
    localparam int DIV = 8;
    localparam int GAP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wake;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    secalm_top #(.TICK_DIV(DIV), .LOAD_GAP(GAP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wake(wake)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Drive at a negedge, commit at the posedge, return at the next negedge.
    task automatic bus_write(input logic a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic load_time(input logic [31:0] v);
        bus_write(1'b0, v);
        if (GAP > 1) cycles(GAP - 1);
        bus_write(1'b0, v);
    endtask

    task automatic t_reset;
        logic [31:0] r;
        bus_read(1'b0, r); check("R1 time", r, 32'h0);
        bus_read(1'b1, r); check("R1 alarm", r, 32'h01FF_FFFF);
        check("R1 wake", {31'b0, wake}, 32'h0);
    endtask

    task automatic t_load;
        logic [31:0] r;
        load_time(32'h1234_5678);
        bus_read(1'b0, r); check("R3 loaded", r, 32'h1234_5678);
        cycles(DIV - 1);
        bus_read(1'b0, r); check("R2 before step", r, 32'h1234_5678);
        cycles(1);
        bus_read(1'b0, r); check("R2 one step", r, 32'h1234_5679);
    endtask

    task automatic t_single_and_mismatch;
        logic [31:0] r;
        load_time(32'h0000_1000);
        bus_write(1'b0, 32'hAAAA_0000);
        cycles(2);
        bus_read(1'b0, r); check("R4 lone write", r, 32'h0000_1000);
        load_time(32'h0000_2000);
        bus_write(1'b0, 32'h0000_3000);
        cycles(GAP - 1);
        bus_write(1'b0, 32'h0000_4000);
        bus_read(1'b0, r); check("R4 mismatch", r, 32'h0000_2000);
        cycles(GAP - 1);
        bus_write(1'b0, 32'h0000_4000);
        bus_read(1'b0, r); check("R4 rearmed", r, 32'h0000_4000);
    endtask

    task automatic t_early;
        logic [31:0] r;
        load_time(32'h0000_5000);
        bus_write(1'b0, 32'h0000_6000);
        bus_write(1'b0, 32'h0000_6000);
        bus_read(1'b0, r); check("R5 gap 1", r, 32'h0000_5000);
        cycles(GAP - 2);
        bus_write(1'b0, 32'h0000_6000);
        bus_read(1'b0, r); check("R5 gap short by 1", r, 32'h0000_5000);
        cycles(GAP - 1);
        bus_write(1'b0, 32'h0000_6000);
        bus_read(1'b0, r); check("R5 gap exact", r, 32'h0000_6000);
    endtask

    task automatic t_rollover;
        logic [31:0] r;
        load_time(32'hFFFF_FFFF);
        cycles(DIV);
        bus_read(1'b0, r); check("R2 wrap", r, 32'h0);
        cycles(DIV);
        bus_read(1'b0, r); check("R2 after wrap", r, 32'h1);
    endtask

    task automatic t_fields;
        logic [31:0] r;
        bus_write(1'b1, 32'hFC00_0123);
        bus_read(1'b1, r); check("R6 upper bits ignored", r, 32'h0000_0123);
        bus_write(1'b1, 32'h0200_0456);
        bus_read(1'b1, r); check("R6 enable bit 25", r, 32'h0200_0456);
        bus_write(1'b1, 32'h0000_0000);
        bus_read(1'b1, r); check("R10 W1C on clear pending", r, 32'h0);
    endtask

    task automatic t_disabled;
        logic [31:0] r;
        bus_write(1'b1, 32'h0000_0005);
        load_time(32'd3);
        cycles(3 * DIV);
        bus_read(1'b0, r); check("R8 count reached", r, 32'd6);
        bus_read(1'b1, r); check("R8 no pending", r, 32'h0000_0005);
        check("R8 no wake", {31'b0, wake}, 32'h0);
    endtask

    task automatic t_fire_and_clear;
        logic [31:0] r;
        bus_write(1'b1, 32'h0200_0000 | 32'd103);
        load_time(32'd100);
        cycles(3 * DIV - 1);
        check("R7 wake before match", {31'b0, wake}, 32'h0);
        cycles(1);
        check("R9 wake on fire", {31'b0, wake}, 32'h1);
        bus_read(1'b1, r); check("R7 pending and reload", r, 32'h07FF_FFFF);
        bus_write(1'b1, 32'h01FF_FFFF);
        check("R9 wake drops with enable", {31'b0, wake}, 32'h0);
        bus_read(1'b1, r); check("R10 pending kept on 0", r, 32'h05FF_FFFF);
        bus_write(1'b1, 32'h05FF_FFFF);
        bus_read(1'b1, r); check("R10 W1C", r, 32'h01FF_FFFF);
    endtask

    task automatic t_low_bits;
        logic [31:0] r;
        bus_write(1'b1, 32'h0200_0007);
        load_time(32'h0200_0005);
        cycles(2 * DIV - 1);
        check("R7 no early fire", {31'b0, wake}, 32'h0);
        cycles(1);
        check("R7 low-bit compare", {31'b0, wake}, 32'h1);
        bus_read(1'b0, r); check("R7 count at fire", r, 32'h0200_0007);
        bus_write(1'b1, 32'h05FF_FFFF);
        check("R9 wake low after W1C", {31'b0, wake}, 32'h0);
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_single_and_mismatch();
        t_early();
        t_rollover();
        t_fields();
        t_disabled();
        t_fire_and_clear();
        t_low_bits();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule